// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight edge-triggered interrupt requests, ranks them by fixed priority, and raises one interrupt line toward the processor. When the processor acknowledges, the controller moves the winning request into service and returns an interrupt vector on the read bus. Software programs it through a one-bit-address register bus. A command port and a data port accept an ordered initialization sequence and, afterwards, mask writes and end-of-interrupt commands.

Two instances can be chained. A master's input can carry a slave's interrupt output. During an acknowledge of that input, the master places the input number on its cascade output. The slave whose programmed identity matches that number supplies the vector. The master does not drive the bus in that case.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A command-port write with bit 4 set starts initialization. It clears the in-service register and pending requests, sets the mask to 0x00, and holds `int_o` low until the sequence ends. The next data-port write gives the vector base. If command bit 1 was 0 (cascaded), a cascade word follows. If command bit 0 was 1, a final mode word follows. Out of reset, the mask is 0xFF and nothing is in service.
- R2: The acknowledge vector for input n is the base with bits [2:0] replaced by n. Base bits [7:3] come from the second initialization word.
- R3: After initialization, a data-port write loads the mask. A data-port read returns the mask. A mask bit of 1 keeps that input from raising `int_o`, but its latched request is kept.
- R4: A request is latched on a rising edge of its input. An input held high produces one request only, and a new request needs a new rising edge.
- R5: Input 0 has the highest priority. `int_o` is high only when a pending unmasked request has a lower index than every in-service bit. An acknowledge takes the lowest-index such request.
- R6: An acknowledge moves the winning request into the in-service register and clears its latched request. A command-port read (`addr_i`=0) returns the in-service register.
- R7: Command 0x20 (non-specific end of interrupt) clears the lowest-index in-service bit.
- R8: Command 0x60+L (specific end of interrupt) clears in-service bit L only. If bit L is clear, nothing changes.
- R9: On a master in cascaded mode, the cascade word is a bitmask of slave inputs. Acknowledging a slave input drives `cas_o` with the input number, keeps `vec_drive_o` low and still sets that input's in-service bit. Acknowledging any other input leaves `cas_o` at 0 and drives the vector.
- R10: On a slave, bits [2:0] of the cascade word are its identity. It answers an acknowledge (in-service update, vector) only when `cas_i` equals that identity. Otherwise its state and `vec_drive_o` stay unchanged and low.
- R11: When a master masks the input that carries a slave, that slave's requests do not reach the master's `int_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, or the vector while `inta_i` is high |
| irq_req_i | input | 8 | Request inputs, edge triggered |
| int_o | output | 1 | Interrupt to the processor (or to a master) |
| inta_i | input | 1 | Acknowledge, one cycle |
| is_master_i | input | 1 | 1 for the master, 0 for a slave |
| cas_i | input | 3 | Cascade number from the master (used by a slave) |
| cas_o | output | 3 | Cascade number during an acknowledge of a slave input |
| vec_drive_o | output | 1 | High while this instance supplies the vector |

## Verification
A corrupted in-service register shows up at the ports in the first cycle after it goes wrong. It either holds `int_o` low against a higher-priority pending request, or lets a lower one through. The command-port read of that register exposes it directly. A wrong position in the initialization sequence shows as a mask readback that takes a base or cascade value, or as the wrong vector at the next acknowledge. Cascade faults are visible during the acknowledge cycle itself, through `cas_o`, `vec_drive_o` and the slave's vector. The bench chains a master and a slave so that each of these is observed.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_MODE  = 2'd3
  } init_st_e;

  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
  localparam logic [2:0] OP_EOI_LVL  = 3'b011;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import prio_irq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic                init_start_o,
  output logic                ready_o,
  output logic                single_o,
  output logic [DW-IDX_W-1:0] base_o,
  output logic [DW-1:0]       casc_o,
  output logic                mask_wr_o,
  output logic                ocw_wr_o
);
  init_st_e            st_q;
  logic                single_q, need_mode_q;
  logic [DW-IDX_W-1:0] base_q;
  logic [DW-1:0]       casc_q;
  logic                data_wr;

  assign init_start_o = wr_i && !addr_i && wdata_i[4];
  assign data_wr      = wr_i && addr_i;
  assign ready_o      = (st_q == ST_READY);
  assign mask_wr_o    = data_wr && ready_o;
  assign ocw_wr_o     = wr_i && !addr_i && !wdata_i[4] && !wdata_i[3] && ready_o;
  assign single_o     = single_q;
  assign base_o       = base_q;
  assign casc_o       = casc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_READY;
      single_q    <= 1'b1;
      need_mode_q <= 1'b0;
      base_q      <= '0;
      casc_q      <= '0;
    end else if (init_start_o) begin
      st_q        <= ST_BASE;
      single_q    <= wdata_i[1];
      need_mode_q <= wdata_i[0];
    end else if (data_wr) begin
      case (st_q)
        ST_BASE: begin
          base_q <= wdata_i[DW-1:IDX_W];
          if (!single_q)        st_q <= ST_CASC;
          else if (need_mode_q) st_q <= ST_MODE;
          else                  st_q <= ST_READY;
        end
        ST_CASC: begin
          casc_q <= wdata_i;
          st_q   <= need_mode_q ? ST_MODE : ST_READY;
        end
        ST_MODE: st_q <= ST_READY;
        default: st_q <= ST_READY;
      endcase
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             clear_all_i,
  input  logic [N_IRQ-1:0] ack_clr_i,
  output logic [N_IRQ-1:0] irr_o
);
  logic [N_IRQ-1:0] prev_q, irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      if (clear_all_i) irr_q <= '0;
      else             irr_q <= (irr_q & ~ack_clr_i) | (req_i & ~prev_q);
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N_IRQ = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_IRQ-1:0] irr_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic [N_IRQ-1:0] isr_i,
  output logic             req_valid_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic             isr_any_o,
  output logic [IDX_W-1:0] isr_idx_o
);
  logic [N_IRQ-1:0] pend;
  assign pend = irr_i & ~mask_i;

  always_comb begin
    req_idx_o = '0;
    isr_idx_o = '0;
    for (int i = N_IRQ-1; i >= 0; i--) begin
      if (pend[i])  req_idx_o = IDX_W'(i);
      if (isr_i[i]) isr_idx_o = IDX_W'(i);
    end
  end

  assign isr_any_o   = |isr_i;
  assign req_valid_o = (|pend) && (!isr_any_o || (req_idx_o < isr_idx_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     addr_i,
  input  logic                     wr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  input  logic [N_IRQ-1:0]         irq_req_i,
  output logic                     int_o,
  input  logic                     inta_i,
  input  logic                     is_master_i,
  input  logic [$clog2(N_IRQ)-1:0] cas_i,
  output logic [$clog2(N_IRQ)-1:0] cas_o,
  output logic                     vec_drive_o
);
  import prio_irq_pkg::*;

  localparam int IDX_W  = $clog2(N_IRQ);
  localparam int BASE_W = DW - IDX_W;

  logic              init_start, ready, single, mask_wr, ocw_wr;
  logic [BASE_W-1:0] base;
  logic [DW-1:0]     casc;
  logic [N_IRQ-1:0]  mask_q, isr_q, irr, ack_clr;
  logic              req_valid, isr_any;
  logic [IDX_W-1:0]  req_idx, isr_idx;
  logic              slave_sel, to_slave, ack_fire, eoi_any, eoi_lvl;
  logic [DW-1:0]     vector;

  pic_init_seq #(.DW(DW), .IDX_W(IDX_W)) u_init (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .init_start_o(init_start), .ready_o(ready), .single_o(single),
    .base_o(base), .casc_o(casc), .mask_wr_o(mask_wr), .ocw_wr_o(ocw_wr)
  );

  pic_req_latch #(.N_IRQ(N_IRQ)) u_latch (
    .clk_i, .rst_ni, .req_i(irq_req_i), .clear_all_i(init_start),
    .ack_clr_i(ack_clr), .irr_o(irr)
  );

  pic_prio_resolve #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_prio (
    .irr_i(irr), .mask_i(mask_q), .isr_i(isr_q),
    .req_valid_o(req_valid), .req_idx_o(req_idx),
    .isr_any_o(isr_any), .isr_idx_o(isr_idx)
  );

  // a slave answers only the acknowledge addressed to its identity
  assign slave_sel = is_master_i || (cas_i == casc[IDX_W-1:0]);
  assign to_slave  = is_master_i && !single && casc[req_idx];
  assign ack_fire  = inta_i && ready && req_valid && slave_sel;
  assign ack_clr   = ack_fire ? (N_IRQ'(1) << req_idx) : '0;

  assign eoi_any = ocw_wr && (wdata_i[7:5] == OP_EOI_ANY);
  assign eoi_lvl = ocw_wr && (wdata_i[7:5] == OP_EOI_LVL);

  // no valid request at acknowledge yields the lowest-priority vector
  assign vector      = {base, req_valid ? req_idx : {IDX_W{1'b1}}};
  assign vec_drive_o = inta_i && ready && slave_sel && !(req_valid && to_slave);
  assign cas_o       = (inta_i && ready && req_valid && to_slave) ? req_idx : '0;
  assign int_o       = ready && req_valid;

  always_comb begin
    if (inta_i)      rdata_o = vec_drive_o ? vector : '0;
    else if (addr_i) rdata_o = mask_q;
    else             rdata_o = isr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mask_q <= '1;
    else if (init_start)  mask_q <= '0;
    else if (mask_wr)     mask_q <= wdata_i[N_IRQ-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
    end else if (init_start) begin
      isr_q <= '0;
    end else begin
      isr_q <= (isr_q
                & ~((eoi_any && isr_any) ? (N_IRQ'(1) << isr_idx) : '0)
                & ~(eoi_lvl ? (N_IRQ'(1) << wdata_i[IDX_W-1:0]) : '0))
               | ack_clr;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     addr_i,
  input logic                     wr_i,
  input logic [DW-1:0]            wdata_i,
  input logic                     inta_i,
  input logic                     is_master_i,
  input logic                     int_o,
  input logic                     vec_drive_o,
  input logic [$clog2(N_IRQ)-1:0] cas_o,
  input logic                     ready,
  input logic                     ack_fire,
  input logic [N_IRQ-1:0]         isr_q,
  input logic [N_IRQ-1:0]         irr,
  input logic [N_IRQ-1:0]         mask_q
);
  localparam int IDX_W = $clog2(N_IRQ);

  // R1
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=> (isr_q == '0) && !int_o);

  // R3
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask_q) != '0));

  // R6
  ack_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !wr_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  // R7
  eoi_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && ready && wdata_i == 8'h20 && !inta_i && isr_q != '0)
      |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R8
  eoi_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && ready && wdata_i[7:3] == 5'b01100 && !inta_i)
      |=> !isr_q[$past(wdata_i[IDX_W-1:0])]);

  // R9
  own_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_drive_o && is_master_i) |-> (cas_o == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .inta_i(inta_i), .is_master_i(is_master_i),
  .int_o(int_o), .vec_drive_o(vec_drive_o), .cas_o(cas_o),
  .ready(ready), .ack_fire(ack_fire), .isr_q(isr_q), .irr(irr),
  .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_addr = 1'b0, m_wr = 1'b0, s_addr = 1'b0, s_wr = 1'b0;
  logic [7:0] m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
  logic [7:0] m_req = '0, s_req = '0, m_irq;
  logic       inta = 1'b0;
  logic       m_int, s_int, m_drv, s_drv;
  logic [2:0] m_cas, s_cas_unused;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign m_irq = {m_req[7:3], s_int, m_req[1:0]};

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(m_addr), .wr_i(m_wr),
    .wdata_i(m_wdata), .rdata_o(m_rdata), .irq_req_i(m_irq), .int_o(m_int),
    .inta_i(inta), .is_master_i(1'b1), .cas_i(3'd0), .cas_o(m_cas),
    .vec_drive_o(m_drv)
  );

  prio_irq_ctrl u_slv (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(s_addr), .wr_i(s_wr),
    .wdata_i(s_wdata), .rdata_o(s_rdata), .irq_req_i(s_req), .int_o(s_int),
    .inta_i(inta), .is_master_i(1'b0), .cas_i(m_cas), .cas_o(s_cas_unused),
    .vec_drive_o(s_drv)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit slv, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (slv) begin s_addr = a; s_wdata = d; s_wr = 1'b1; end
    else     begin m_addr = a; m_wdata = d; m_wr = 1'b1; end
    @(negedge clk);
    s_wr = 1'b0; m_wr = 1'b0;
    #1;
  endtask

  task automatic rd_reg(input bit slv, input bit a, output logic [7:0] d);
    @(negedge clk);
    if (slv) s_addr = a; else m_addr = a;
    #1;
    d = slv ? s_rdata : m_rdata;
  endtask

  task automatic pulse_m(input logic [7:0] bits);
    @(negedge clk); m_req = m_req | bits;
    @(negedge clk); m_req = m_req & ~bits;
    #1;
  endtask

  task automatic pulse_s(input logic [7:0] bits);
    @(negedge clk); s_req = s_req | bits;
    @(negedge clk); s_req = s_req & ~bits;
    @(negedge clk);  // master latches the slave's line one cycle later
    #1;
  endtask

  task automatic ack(output logic [7:0] vec, output logic md, output logic sd,
                     output logic [2:0] cas);
    @(negedge clk); inta = 1'b1;
    #1;
    md = m_drv; sd = s_drv; cas = m_cas;
    vec = m_drv ? m_rdata : s_rdata;
    @(negedge clk); inta = 1'b0;
    #1;
  endtask

  task automatic init_pair();
    wr_reg(0, 0, 8'h11); wr_reg(0, 1, 8'h20); wr_reg(0, 1, 8'h04); wr_reg(0, 1, 8'h01);
    wr_reg(1, 0, 8'h11); wr_reg(1, 1, 8'h28); wr_reg(1, 1, 8'h02); wr_reg(1, 1, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 reset int_o", {7'd0, m_int}, 8'h00);
    rd_reg(0, 1, d); chk("R1 reset mask", d, 8'hFF);
    rd_reg(0, 0, d); chk("R1 reset isr", d, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    init_pair();
    rd_reg(0, 1, d); chk("R1 mask after init", d, 8'h00);
    rd_reg(1, 1, d); chk("R1 slave mask after init", d, 8'h00);
    chk("R1 no int after init", {6'd0, s_int, m_int}, 8'h00);
  endtask

  task automatic t_vector();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    pulse_m(8'h20);
    chk("R4 edge raises int", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R2 vector input 5", v, 8'h25);
    chk("R9 own input cas", {5'd0, c}, 8'h00);
    chk("R9 own input drives", {7'd0, md}, 8'h01);
    rd_reg(0, 0, d); chk("R6 isr after ack", d, 8'h20);
    chk("R6 request consumed", {7'd0, m_int}, 8'h00);
    wr_reg(0, 0, 8'h20);
    rd_reg(0, 0, d); chk("R7 eoi clears", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    wr_reg(0, 1, 8'h01);
    rd_reg(0, 1, d); chk("R3 mask readback", d, 8'h01);
    pulse_m(8'h01);
    chk("R3 masked no int", {7'd0, m_int}, 8'h00);
    wr_reg(0, 1, 8'h00);
    chk("R3 kept request after unmask", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R2 vector input 0", v, 8'h20);
    wr_reg(0, 0, 8'h20);
  endtask

  task automatic t_edge();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    @(negedge clk); m_req[3] = 1'b1;
    @(negedge clk); #1;
    chk("R4 held input raises", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R2 vector input 3", v, 8'h23);
    wr_reg(0, 0, 8'h20);
    repeat (3) @(negedge clk);
    #1;
    chk("R4 held high no repeat", {7'd0, m_int}, 8'h00);
    @(negedge clk); m_req[3] = 1'b0;
    @(negedge clk); m_req[3] = 1'b1;
    @(negedge clk); #1;
    chk("R4 new edge raises", {7'd0, m_int}, 8'h01);
    m_req[3] = 1'b0;
    ack(v, md, sd, c);
    wr_reg(0, 0, 8'h20);
    rd_reg(0, 0, d); chk("R7 isr clear after edge test", d, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    pulse_m(8'h42);
    ack(v, md, sd, c);
    chk("R5 lowest index wins", v, 8'h21);
    chk("R5 lower priority blocked", {7'd0, m_int}, 8'h00);
    pulse_m(8'h01);
    chk("R5 higher priority nests", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R5 nested vector", v, 8'h20);
    rd_reg(0, 0, d); chk("R6 two in service", d, 8'h03);
    wr_reg(0, 0, 8'h20);
    rd_reg(0, 0, d); chk("R7 clears lowest index", d, 8'h02);
    chk("R5 still blocked by level 1", {7'd0, m_int}, 8'h00);
    wr_reg(0, 0, 8'h61);
    rd_reg(0, 0, d); chk("R8 specific clears level 1", d, 8'h00);
    chk("R5 unblocked after eoi", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R2 vector input 6", v, 8'h26);
    wr_reg(0, 0, 8'h63);
    rd_reg(0, 0, d); chk("R8 clear bit untouched", d, 8'h40);
    wr_reg(0, 0, 8'h66);
    rd_reg(0, 0, d); chk("R8 specific clears level 6", d, 8'h00);
  endtask

  task automatic t_cascade();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    pulse_s(8'h10);
    chk("R9 slave request reaches master", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R9 cas number", {5'd0, c}, 8'h02);
    chk("R9 master releases bus", {7'd0, md}, 8'h00);
    chk("R10 slave drives", {7'd0, sd}, 8'h01);
    chk("R2 slave vector", v, 8'h2C);
    rd_reg(0, 0, d); chk("R9 master isr slave input", d, 8'h04);
    rd_reg(1, 0, d); chk("R10 slave isr", d, 8'h10);
    wr_reg(1, 0, 8'h20);
    wr_reg(0, 0, 8'h62);
    rd_reg(0, 0, d); chk("R8 master cascade eoi", d, 8'h00);
  endtask

  task automatic t_slave_gate();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    wr_reg(0, 1, 8'h04);
    pulse_s(8'h02);
    chk("R11 slave int high", {7'd0, s_int}, 8'h01);
    chk("R11 masked cascade blocks", {7'd0, m_int}, 8'h00);
    pulse_m(8'h80);
    ack(v, md, sd, c);
    chk("R10 master own vector", v, 8'h27);
    chk("R10 slave stays off bus", {7'd0, sd}, 8'h00);
    rd_reg(1, 0, d); chk("R10 slave isr unchanged", d, 8'h00);
    wr_reg(0, 0, 8'h67);
    wr_reg(0, 1, 8'h00);
    chk("R3 unmask cascade", {7'd0, m_int}, 8'h01);
    ack(v, md, sd, c);
    chk("R10 matched slave vector", v, 8'h29);
    wr_reg(1, 0, 8'h20);
    wr_reg(0, 0, 8'h20);
    rd_reg(0, 0, d); chk("R7 master cleared", d, 8'h00);
  endtask

  task automatic t_reinit();
    logic [7:0] v, d; logic md, sd; logic [2:0] c;
    pulse_m(8'h10);
    ack(v, md, sd, c);
    wr_reg(0, 0, 8'h13);
    rd_reg(0, 0, d); chk("R1 init clears isr", d, 8'h00);
    chk("R1 int low during init", {7'd0, m_int}, 8'h00);
    pulse_m(8'h08);
    chk("R1 int held low mid-sequence", {7'd0, m_int}, 8'h00);
    wr_reg(0, 1, 8'h40);
    wr_reg(0, 1, 8'h01);
    wr_reg(0, 1, 8'h5A);
    rd_reg(0, 1, d); chk("R1 single mode skips cascade word", d, 8'h5A);
    wr_reg(0, 1, 8'h00);
    ack(v, md, sd, c);
    chk("R2 new base vector", v, 8'h43);
    wr_reg(0, 0, 8'h20);
    wr_reg(0, 0, 8'h11); wr_reg(0, 1, 8'h20); wr_reg(0, 1, 8'h04); wr_reg(0, 1, 8'h01);
    rd_reg(0, 1, d); chk("R1 mask zero after reinit", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_init();
    t_vector();
    t_mask();
    t_edge();
    t_prio();
    t_cascade();
    t_slave_gate();
    t_reinit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule